// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block chooses which of five interrupt request flags a processor core should service next. The five flags are two external requests, two timer overflows and one serial flag that merges transmit and receive. Each flag is gated by its own enable bit and by a global enable. Each source is assigned to a high or low level by a per-source bit. Within a level, a fixed ordering by source index breaks ties.

The core tells the block when a machine cycle happens and whether that cycle ends the current instruction. It also reports whether the ending instruction is a return from interrupt or touches the enable or level register. When a response is allowed, the block registers a take strobe with the entry address, the level taken and a one-hot acknowledge. The acknowledge clears the flag at its owner. The block keeps one in-service bit per level. A return clears the highest in-service level.

Top module: `irq_arbiter`

## Requirements
- R1: The entry address of a taken source is 0x0003 + 8*index, with index 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1 and 4 = serial. The addresses are therefore 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R2: The enable register (cfg_sel=0) has the global enable at bit 7 and one enable per source at bits 4..0, where bit i belongs to source i. When bit 7 is 0, no source is taken. A source whose own bit is 0 is never taken.
- R3: The level register (cfg_sel=1) bit i set to 1 places source i at high level, and 0 places it at low level. After reset both registers read zero and nothing is in service.
- R4: Among pending enabled requests at the same level, the lowest index wins.
- R5: A pending high-level request wins over any low-level one. With sources 1 and 2 at high level and all five pending, the sources are served in the order 1, 2, 0, 3, 4.
- R6: Requests are evaluated only in a cycle where mc_tick and last_cycle are both 1. No take occurs in any other cycle.
- R7: A low-level request is not taken while either level is in service. A high-level request is not taken while the high level is in service, but it is taken while only the low level is in service.
- R8: An instruction end flagged instr_reti or instr_cfg gives no take, and the next instruction end gives no take either. The instruction end after that one may take.
- R9: Each take raises exactly one ack bit, bit i, for sources 0 to 3. A take of source 4 raises no ack bit. Ack is 0 whenever take is 0.
- R10: A take sets the in-service bit of its level (isv[1] high, isv[0] low). An instruction end with instr_reti clears isv[1] if it is set, and otherwise clears isv[0].
- R11: take, take_hi, vector and ack are registered. They appear in the clock after the deciding edge and last one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | Machine cycle strobe |
| last_cycle | input | 1 | Current machine cycle ends the instruction |
| instr_reti | input | 1 | Ending instruction is a return from interrupt |
| instr_cfg | input | 1 | Ending instruction accesses the enable or level register |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the enable register, 1 selects the level register |
| cfg_wdata | input | 8 | Register write data |
| req | input | 5 | Request flags, bit i = source i |
| en_q | output | 8 | Enable register contents |
| pri_q | output | 5 | Level register contents |
| isv | output | 2 | In-service bits {high, low} |
| take | output | 1 | Take-interrupt strobe |
| take_hi | output | 1 | Level of the taken source |
| vector | output | 16 | Entry address of the taken source |
| ack | output | 4 | Flag-clear acknowledge for sources 0 to 3 |

## Verification
The bench tries several enable and level register settings against all-pending, single-pending and sparse request sets. All-pending sets separate the within-level ordering from the cross-level choice. Sets in which only a disabled or globally masked source is pending show whether gating is applied. A drain of all five pending sources, with returns between takes, checks the whole service order together with the deferral that follows each return. Directed nesting and timing cases tell apart the same-level block, the high-over-low preemption and the single-cycle, instruction-end-only strobe.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic              last_cycle,
  input  logic              instr_reti,
  input  logic              instr_cfg,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  input  logic [4:0]        req,
  output logic [7:0]        en_q,
  output logic [4:0]        pri_q,
  output logic [1:0]        isv,
  output logic              take,
  output logic              take_hi,
  output logic [ADDR_W-1:0] vector,
  output logic [3:0]        ack
);
  localparam int NSRC = 5;
  localparam logic [7:0] EN_MASK = 8'h9F;

  logic [NSRC-1:0] act, hi_set, lo_set, pick;
  logic            win_hi, any_act, lvl_free, instr_end, grant, defer_q;
  logic [2:0]      idx;

  assign act       = req & en_q[NSRC-1:0] & {NSRC{en_q[7]}};
  assign hi_set    = act & pri_q;
  assign lo_set    = act & ~pri_q;
  assign win_hi    = |hi_set;
  assign pick      = win_hi ? hi_set : lo_set;
  assign any_act   = |act;
  assign lvl_free  = win_hi ? !isv[1] : !(isv[1] | isv[0]);
  assign instr_end = mc_tick & last_cycle;
  assign grant     = instr_end & any_act & lvl_free & !defer_q & !instr_reti & !instr_cfg;

  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pick[i]) idx = 3'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pri_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) pri_q <= cfg_wdata[NSRC-1:0];
      else         en_q  <= cfg_wdata & EN_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         defer_q <= 1'b0;
    else if (instr_end) defer_q <= instr_reti | instr_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isv <= '0;
    end else if (grant) begin
      if (win_hi) isv[1] <= 1'b1;
      else        isv[0] <= 1'b1;
    end else if (instr_end && instr_reti) begin
      if (isv[1]) isv[1] <= 1'b0;
      else        isv[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take    <= 1'b0;
      take_hi <= 1'b0;
      vector  <= '0;
      ack     <= '0;
    end else begin
      take    <= grant;
      take_hi <= grant & win_hi;
      vector  <= grant ? ADDR_W'(VEC_BASE + VEC_STEP * int'(idx)) : '0;
      for (int i = 0; i < 4; i++)
        ack[i] <= grant && (int'(idx) == i);
    end
  end
endmodule

module irq_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mc_tick,
  input logic        last_cycle,
  input logic        instr_reti,
  input logic        instr_cfg,
  input logic [7:0]  en_q,
  input logic [1:0]  isv,
  input logic        take,
  input logic        take_hi,
  input logic [15:0] vector,
  input logic [3:0]  ack
);
  a_r9_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ack));
  a_r9_ack_needs_take: assert property (@(posedge clk) disable iff (!rst_n) (ack != 4'd0) |-> take);
  a_r9_ack_on_clearable: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vector != 16'h0023) |-> $countones(ack) == 1);
  a_r1_vector_set: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (vector == 16'h0003 || vector == 16'h000B || vector == 16'h0013 ||
              vector == 16'h001B || vector == 16'h0023));
  a_r6_at_instr_end: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(mc_tick && last_cycle));
  a_r2_global_enable: assert property (@(posedge clk) disable iff (!rst_n) take |-> $past(en_q[7]));
  a_r8_not_on_special_end: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !$past(instr_reti || instr_cfg));
  a_r7_low_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_hi) |-> $past(isv) == 2'b00);
  a_r7_high_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_hi) |-> !$past(isv[1]));
  a_r10_level_marked: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (take_hi ? isv[1] : isv[0]));
endmodule

bind irq_arbiter irq_arbiter_chk u_irq_arbiter_chk (
  .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .last_cycle(last_cycle),
  .instr_reti(instr_reti), .instr_cfg(instr_cfg), .en_q(en_q), .isv(isv),
  .take(take), .take_hi(take_hi), .vector(vector), .ack(ack)
);

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mc_tick = 1'b0, last_cycle = 1'b0, instr_reti = 1'b0, instr_cfg = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [4:0]  req = '0;
  logic [7:0]  en_q;
  logic [4:0]  pri_q;
  logic [1:0]  isv;
  logic        take, take_hi;
  logic [15:0] vector;
  logic [3:0]  ack;

  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .last_cycle(last_cycle),
    .instr_reti(instr_reti), .instr_cfg(instr_cfg), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req(req), .en_q(en_q), .pri_q(pri_q), .isv(isv),
    .take(take), .take_hi(take_hi), .vector(vector), .ack(ack)
  );

  // {enable[7:0], level[4:0], req[4:0], exp_take, exp_vector[15:0]}
  localparam logic [34:0] TBL [0:10] = '{
    {8'h9F, 5'h00, 5'h1F, 1'b1, 16'h0003},
    {8'h9F, 5'h00, 5'h1E, 1'b1, 16'h000B},
    {8'h9F, 5'h00, 5'h10, 1'b1, 16'h0023},
    {8'h1F, 5'h00, 5'h1F, 1'b0, 16'h0000},
    {8'h9D, 5'h00, 5'h02, 1'b0, 16'h0000},
    {8'h9D, 5'h00, 5'h06, 1'b1, 16'h0013},
    {8'h9F, 5'h06, 5'h1F, 1'b1, 16'h000B},
    {8'h9F, 5'h06, 5'h1D, 1'b1, 16'h0013},
    {8'h9F, 5'h10, 5'h11, 1'b1, 16'h0023},
    {8'h88, 5'h00, 5'h08, 1'b1, 16'h001B},
    {8'h80, 5'h00, 5'h1F, 1'b0, 16'h0000}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; req = '0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // outputs valid at the negedge after the instruction-end edge
  task automatic end_instr(input logic rt, input logic cf);
    @(negedge clk); mc_tick = 1'b1; last_cycle = 1'b1; instr_reti = rt; instr_cfg = cf;
    @(negedge clk); mc_tick = 1'b0; last_cycle = 1'b0; instr_reti = 1'b0; instr_cfg = 1'b0;
  endtask

  task automatic expect_take(input string tag, input logic et, input logic [15:0] ev);
    chk(take == et, tag, 32'(take), 32'(et));
    if (et) chk(vector == ev, tag, 32'(vector), 32'(ev));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] ord_v [5] = '{16'h000B, 16'h0013, 16'h0003, 16'h001B, 16'h0023};
    int          ord_s [5] = '{1, 2, 0, 3, 4};
    logic [3:0]  exp_ack;
    do_reset();
    // R3 reset state
    chk(en_q == 8'h00, "R3 reset enable", 32'(en_q), 0);
    chk(pri_q == 5'h00, "R3 reset level", 32'(pri_q), 0);
    chk(isv == 2'b00, "R3 reset in-service", 32'(isv), 0);
    chk(take == 1'b0, "R11 reset take", 32'(take), 0);

    // table walk: R1 R2 R4 R5
    for (int k = 0; k < 11; k++) begin
      do_reset();
      wr(1'b0, TBL[k][34:27]);
      wr(1'b1, {3'b000, TBL[k][26:22]});
      req = TBL[k][21:17];
      end_instr(1'b0, 1'b0);
      expect_take($sformatf("R1/R2/R4/R5 table row %0d", k), TBL[k][16], TBL[k][15:0]);
    end

    // R6: no take without a full instruction end; R11 one-cycle pulse
    do_reset();
    wr(1'b0, 8'h9F);
    req = 5'h01;
    @(negedge clk); mc_tick = 1'b1;
    @(negedge clk); mc_tick = 1'b0; last_cycle = 1'b1;
    @(negedge clk); last_cycle = 1'b0;
    chk(take == 1'b0 && isv == 2'b00, "R6 no end no take", 32'(take), 0);
    end_instr(1'b0, 1'b0);
    expect_take("R6 take at end", 1'b1, 16'h0003);
    chk(ack == 4'b0001, "R9 ack ext0", 32'(ack), 1);
    @(negedge clk);
    chk(take == 1'b0 && ack == 4'b0000, "R11 pulse one clock", 32'(take), 0);

    // R5 R8 R10: full drain with levels 1 and 2 high
    do_reset();
    wr(1'b0, 8'h9F);
    wr(1'b1, 8'h06);
    req = 5'h1F;
    for (int k = 0; k < 5; k++) begin
      end_instr(1'b0, 1'b0);
      expect_take($sformatf("R5 order step %0d", k), 1'b1, ord_v[k]);
      exp_ack = (ord_s[k] < 4) ? 4'(1 << ord_s[k]) : 4'b0000;
      chk(ack == exp_ack, "R9 ack per source", 32'(ack), 32'(exp_ack));
      chk(isv == ((k < 2) ? 2'b10 : 2'b01), "R10 level marked", 32'(isv), (k < 2) ? 2 : 1);
      req[ord_s[k]] = 1'b0;
      end_instr(1'b1, 1'b0);
      chk(take == 1'b0 && isv == 2'b00, "R10 return clears", 32'(isv), 0);
      end_instr(1'b0, 1'b0);
      chk(take == 1'b0, "R8 deferral after return", 32'(take), 0);
    end

    // R7 nesting and same-level block
    do_reset();
    wr(1'b0, 8'h9F);
    wr(1'b1, 8'h02);
    req = 5'h01;
    end_instr(1'b0, 1'b0);
    expect_take("R7 low taken", 1'b1, 16'h0003);
    req = 5'h08;
    end_instr(1'b0, 1'b0);
    chk(take == 1'b0, "R7 same level blocked", 32'(take), 0);
    req = 5'h0A;
    end_instr(1'b0, 1'b0);
    expect_take("R7 high preempts low", 1'b1, 16'h000B);
    chk(isv == 2'b11, "R10 both in service", 32'(isv), 3);
    req = 5'h0B;
    end_instr(1'b0, 1'b0);
    chk(take == 1'b0, "R7 high blocked by high", 32'(take), 0);
    end_instr(1'b1, 1'b0);
    chk(isv == 2'b01, "R10 return clears high first", 32'(isv), 1);
    end_instr(1'b1, 1'b0);
    chk(isv == 2'b00, "R10 return clears low", 32'(isv), 0);

    // R8 register-access deferral
    do_reset();
    wr(1'b0, 8'h9F);
    req = 5'h04;
    end_instr(1'b0, 1'b1);
    chk(take == 1'b0, "R8 no take on cfg end", 32'(take), 0);
    end_instr(1'b0, 1'b0);
    chk(take == 1'b0, "R8 no take on next end", 32'(take), 0);
    end_instr(1'b0, 1'b0);
    expect_take("R8 take after one more", 1'b1, 16'h0013);

    // R2 per-source disable
    do_reset();
    wr(1'b0, 8'h8F);
    req = 5'h10;
    end_instr(1'b0, 1'b0);
    chk(take == 1'b0, "R2 serial disabled", 32'(take), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule